// File: doc/BRIEF.md
# Line-Allocate Store Backup Queue

This block keeps an ordered log of the stores issued by a line-allocating store instruction so that they can later be replayed to memory or thrown away. Each logged store carries its full word address and its data word. Only stores that the surrounding logic flags as cacheable are logged; the rest pass by untouched.

Two commands act on the log. A discard empties it at once. An invalidate-line command names a 32-byte line: the block scans the log, writes every entry of that line to memory in the order the entries were logged, and removes each one as its write is accepted. Entries of other lines stay in place, in their original relative order. While a scan is running the block raises `busy_o` and holds off all new commands.

Top module: `store_backup_queue`

## Requirements
- R1: After reset the log is empty: `count_o` is 0, `empty_o` is 1, `full_o`, `busy_o`, `overflow_o` and `mem_valid_o` are 0.
- R2: A record accepted with `rec_cacheable_i` high and the log not full appends one entry (count rises by one at the next edge); a record with `rec_cacheable_i` low changes nothing.
- R3: A cacheable record accepted while the log holds DEPTH entries is dropped and sets `overflow_o`, which stays set until a discard or reset.
- R4: An accepted discard empties the log and clears `overflow_o` by the next edge.
- R5: An invalidate writes to memory exactly the entries whose address bits [31:5] equal those of `inv_addr_i`, each with its logged address and data; address bits [4:0] take no part in matching.
- R6: Matching entries leave oldest first, one per cycle in which `mem_valid_o` and `mem_ready_i` are both high; while `mem_valid_o` is high and `mem_ready_i` low, address and data hold steady.
- R7: Each accepted write removes its entry; non-matching entries keep their relative order and remain in the log.
- R8: `busy_o` rises the edge after an invalidate is accepted and falls the edge after the cycle in which no matching entry remains; while busy, `rec_ready_o`, `disc_ready_o` and `inv_ready_o` are low and records or discards have no effect.
- R9: `full_o` is high exactly when the count equals DEPTH, `empty_o` exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record request |
| rec_ready_o | output | 1 | Record accepted this cycle |
| rec_addr_i | input | 32 | Store address to log |
| rec_data_i | input | 32 | Store data to log |
| rec_cacheable_i | input | 1 | Store targets a cacheable region |
| disc_valid_i | input | 1 | Discard request |
| disc_ready_o | output | 1 | Discard accepted this cycle |
| inv_valid_i | input | 1 | Invalidate-line request |
| inv_ready_o | output | 1 | Invalidate accepted this cycle |
| inv_addr_i | input | 32 | Address naming the line to flush |
| mem_valid_o | output | 1 | Write-back request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 32 | Write-back address |
| mem_data_o | output | 32 | Write-back data |
| busy_o | output | 1 | Invalidate scan in progress |
| full_o | output | 1 | Log holds DEPTH entries |
| empty_o | output | 1 | Log holds no entry |
| overflow_o | output | 1 | Sticky: a cacheable record was dropped |
| count_o | output | $clog2(DEPTH+1) | Number of logged entries |

## Verification
Record and discard results appear in `count_o`, `empty_o`, `full_o` and `overflow_o` one edge after acceptance, and the bench samples them one nanosecond after that edge. An invalidate raises `busy_o` one edge after acceptance; the first write-back is then already presented combinationally, each later one appears the edge after the previous handshake, and `busy_o` falls one edge after the last write (or one edge after it rose when nothing matches), so the bench walks the scan cycle by cycle against its own ordered model. Stalled handshakes are checked for stable address and data across an edge, and records or discards driven during that stall are checked to leave the count unchanged.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } sbq_entry_t;
endpackage

// File: rtl/sbq_line_match.sv
module sbq_line_match #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr_i,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [ADDR_W-OFF_W-1:0]      line_i,
  output logic [DEPTH-1:0]             hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_o[g] = (CNT_W'(g) < cnt_i) && (ent_addr_i[g][ADDR_W-1:OFF_W] == line_i);
  end
endmodule

// File: rtl/sbq_oldest_pick.sv
module sbq_oldest_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) assert (req_i[idx_o]) else $error("pick index not a requester (R6)");
  end
endmodule

// File: rtl/store_backup_queue.sv
module store_backup_queue
  import sbq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 32,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  output logic              rec_ready_o,
  input  logic [31:0]       rec_addr_i,
  input  logic [31:0]       rec_data_i,
  input  logic              rec_cacheable_i,
  input  logic              disc_valid_i,
  output logic              disc_ready_o,
  input  logic              inv_valid_i,
  output logic              inv_ready_o,
  input  logic [31:0]       inv_addr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic              busy_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int LN_W  = ADDR_W - OFF_W;

  sbq_entry_t              ent_q [DEPTH];
  logic [CNT_W-1:0]        cnt_q;
  logic                    busy_q, ovf_q;
  logic [LN_W-1:0]         line_q;

  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0]        hit_vec;
  logic [IDX_W-1:0]        pick_idx;
  logic                    hit_any;
  logic                    rec_fire, disc_fire, inv_fire, wr_fire, full;
  logic                    unused_inv_off;

  assign unused_inv_off = ^inv_addr_i[OFF_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_addr
    assign ent_addr[g] = ent_q[g].addr;
  end

  sbq_line_match #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .ent_addr_i(ent_addr), .cnt_i(cnt_q), .line_i(line_q), .hit_o(hit_vec)
  );

  sbq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .req_i(hit_vec), .idx_o(pick_idx), .any_o(hit_any)
  );

  assign full         = (cnt_q == CNT_W'(DEPTH));
  assign rec_ready_o  = !busy_q;
  assign disc_ready_o = !busy_q;
  assign inv_ready_o  = !busy_q;
  assign rec_fire     = rec_valid_i  && !busy_q;
  assign disc_fire    = disc_valid_i && !busy_q;
  assign inv_fire     = inv_valid_i  && !busy_q;
  assign mem_valid_o  = busy_q && hit_any;
  assign mem_addr_o   = ent_q[pick_idx].addr;
  assign mem_data_o   = ent_q[pick_idx].data;
  assign wr_fire      = mem_valid_o && mem_ready_i;
  assign busy_o       = busy_q;
  assign full_o       = full;
  assign empty_o      = (cnt_q == '0);
  assign overflow_o   = ovf_q;
  assign count_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
      line_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (busy_q) begin
      if (wr_fire) begin
        // close the gap left by the written entry; order of the rest is kept
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IDX_W'(i) >= pick_idx) ent_q[i] <= ent_q[i+1];
        end
        cnt_q <= cnt_q - 1'b1;
      end else if (!hit_any) begin
        busy_q <= 1'b0;
      end
    end else begin
      if (disc_fire) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (rec_fire && rec_cacheable_i) begin
        if (full) begin
          ovf_q <= 1'b1;
        end else begin
          ent_q[cnt_q[IDX_W-1:0]] <= '{addr: rec_addr_i, data: rec_data_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (inv_fire) begin
        busy_q <= 1'b1;
        line_q <= inv_addr_i[ADDR_W-1:OFF_W];
      end
    end
  end

  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  p_write_needs_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> busy_o);
  p_hold_on_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));
  p_write_removes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (count_o == $past(count_o) - 1'b1));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_fire && rec_cacheable_i && full_o && !disc_fire) |=> (overflow_o && full_o));
  p_discard_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_fire |=> (empty_o && !overflow_o));
  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!rec_ready_o && !disc_ready_o && !inv_ready_o));
  p_busy_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_fire |=> busy_o);
endmodule

// File: tb/store_backup_queue_test.sv
`timescale 1ns/1ps
module store_backup_queue_test;
  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rec_valid_i = 0, rec_cacheable_i = 0, disc_valid_i = 0, inv_valid_i = 0, mem_ready_i = 0;
  logic [31:0] rec_addr_i = 0, rec_data_i = 0, inv_addr_i = 0;
  logic rec_ready_o, disc_ready_o, inv_ready_o, mem_valid_o, busy_o, full_o, empty_o, overflow_o;
  logic [31:0] mem_addr_o, mem_data_o;
  logic [CNT_W-1:0] count_o;

  always #10 clk_i = ~clk_i;

  store_backup_queue #(.DEPTH(DEPTH)) uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_addr [DEPTH];
  logic [31:0] m_data [DEPTH];
  int m_cnt = 0;
  bit m_ovf = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic chk_status(input string tag);
    chk(int'(count_o) == m_cnt, {tag, " count (R2/R7)"}, 32'(count_o), 32'(m_cnt));
    chk(full_o == (m_cnt == DEPTH), {tag, " full R9"}, 32'(full_o), 32'(m_cnt == DEPTH));
    chk(empty_o == (m_cnt == 0), {tag, " empty R9"}, 32'(empty_o), 32'(m_cnt == 0));
    chk(overflow_o == m_ovf, {tag, " overflow R3"}, 32'(overflow_o), 32'(m_ovf));
  endtask

  function automatic logic [31:0] line_base(input int s);
    return (s == 3) ? 32'h9000_0020 : 32'h1000_0000 + 32'(s) * 32;
  endfunction

  task automatic do_rec(input logic [31:0] a, input logic [31:0] d, input bit c);
    rec_valid_i = 1; rec_addr_i = a; rec_data_i = d; rec_cacheable_i = c;
    chk(rec_ready_o == 1'b1, "rec ready idle R8", 32'(rec_ready_o), 1);
    step();
    rec_valid_i = 0;
    if (c) begin
      if (m_cnt < DEPTH) begin m_addr[m_cnt] = a; m_data[m_cnt] = d; m_cnt++; end
      else m_ovf = 1;
    end
    chk_status(c ? "record R2" : "noncacheable R2");
  endtask

  task automatic do_disc();
    disc_valid_i = 1;
    step();
    disc_valid_i = 0;
    m_cnt = 0; m_ovf = 0;
    chk_status("discard R4");
  endtask

  task automatic do_inv(input logic [31:0] a);
    int nw = 0;
    int keep = 0;
    inv_valid_i = 1; inv_addr_i = a;
    chk(inv_ready_o == 1'b1, "inv ready idle R8", 32'(inv_ready_o), 1);
    step();
    inv_valid_i = 0;
    chk(busy_o == 1'b1, "busy rise R8", 32'(busy_o), 1);
    for (int i = 0; i < m_cnt; i++) begin
      if (m_addr[i][31:5] == a[31:5]) begin
        if (nw % 2 == 1) begin
          rec_valid_i = 1; rec_cacheable_i = 1; disc_valid_i = 1;
          chk(rec_ready_o == 0 && disc_ready_o == 0 && inv_ready_o == 0, "ready low busy R8",
              {29'b0, rec_ready_o, disc_ready_o, inv_ready_o}, 0);
          chk(mem_addr_o == m_addr[i], "stall addr R6", mem_addr_o, m_addr[i]);
          step();
          rec_valid_i = 0; disc_valid_i = 0;
          chk(mem_valid_o == 1'b1, "stall valid held R6", 32'(mem_valid_o), 1);
          chk(mem_addr_o == m_addr[i], "stall addr held R6", mem_addr_o, m_addr[i]);
          chk(mem_data_o == m_data[i], "stall data held R6", mem_data_o, m_data[i]);
        end
        mem_ready_i = 1;
        chk(mem_valid_o == 1'b1, "write valid R5", 32'(mem_valid_o), 1);
        chk(mem_addr_o == m_addr[i], "write addr oldest-first R6", mem_addr_o, m_addr[i]);
        chk(mem_data_o == m_data[i], "write data R5", mem_data_o, m_data[i]);
        step();
        mem_ready_i = 0;
        nw++;
      end
    end
    chk(mem_valid_o == 1'b0, "no extra write R5", 32'(mem_valid_o), 0);
    chk(busy_o == 1'b1, "busy until scan end R8", 32'(busy_o), 1);
    step();
    chk(busy_o == 1'b0, "busy fall R8", 32'(busy_o), 0);
    for (int i = 0; i < m_cnt; i++) begin
      if (m_addr[i][31:5] != a[31:5]) begin
        m_addr[keep] = m_addr[i]; m_data[keep] = m_data[i]; keep++;
      end
    end
    m_cnt = keep;
    chk_status("after invalidate R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #5;
    chk(count_o == 0 && empty_o == 1 && busy_o == 0 && mem_valid_o == 0 && overflow_o == 0 && full_o == 0,
        "reset state R1", {24'b0, 3'(count_o), empty_o, busy_o, mem_valid_o, overflow_o, full_o}, 32'h10);
    #30 rst_ni = 1;
    step();
    chk_status("post reset R1");
    do_inv(32'h1000_0000);
    for (int p = 0; p < 256; p++) begin
      do_disc();
      for (int k = 0; k < DEPTH; k++) begin
        do_rec(line_base((p >> (2 * k)) & 3) + 32'(k) * 4, {16'(p), 16'(k)}, 1'b1);
        if (k == 1 && p % 3 == 0) do_rec(line_base(p & 3), 32'hdead_0000, 1'b0);
      end
      if (p % 8 == 0) do_rec(line_base(0), 32'hbeef_0000, 1'b1);
      do_inv(line_base(p & 3) + 32'h1c);
      do_inv(line_base((p >> 2) & 3));
      for (int s = 0; s < 4; s++) do_inv(line_base(s) + 32'(s) * 4);
      chk(empty_o == 1'b1, "all lines flushed R7", 32'(empty_o), 1);
    end
    do_rec(line_base(1), 32'h1234_5678, 1'b1);
    do_inv(line_base(1) ^ 32'h0000_0040);
    do_inv(line_base(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule